// File: doc/BRIEF.md
# C/I Channel Filtered Transceiver

This block carries the four-bit command/indication field of a frame-structured serial line between a line-side device and a host. Its clock is the serial data clock, which runs at twice the bit rate (1.536 MHz for 768 kbit/s), so every bit lasts two clock cycles. An 8 kHz frame-sync input marks the start of each frame. The C/I field occupies a fixed group of bit positions counted from that sync edge.

On the receive side the field is captured in every frame. A captured value replaces the stored code only when two frames in a row carry the same value. This filters out single-frame disturbances. When the stored code changes, a sticky interrupt is raised, and the host clears it by reading the received code. On the transmit side, a host-written code is shifted into the field of every frame for as long as the host leaves it unchanged. All other bit positions are driven high (idle).

The host port is a one-bit register select with read and write strobes. Select 0 is the received code, which is read-only, and select 1 is the transmit code, which can be read and written.

Top module: `ci_transceiver`

## Requirements
- R1: After reset the received code reads 4'b1111, the transmit code reads 4'b1111, irq is 0 and dout is 1.
- R2: A clock edge that samples fsc high after it was low starts a frame. The cycle after that edge is cycle 0, and bit b spans cycles 2b and 2b+1. The C/I field is bits SLOT_POS to SLOT_POS+3 (26 to 29 by default), with the most significant code bit first.
- R3: During the C/I field bits of every frame, dout carries the transmit code, most significant bit first. Outside the field, dout is 1.
- R4: A write with sel=1 loads wdata into the transmit code, which reads back on rdata when sel=1. The transmit code changes only on such a write.
- R5: din is sampled at the clock edge that ends the second cycle of each bit, so its value in the first cycle of a bit has no effect.
- R6: A received value is loaded into the received code only when the same value has been captured in two consecutive frames. The new code is visible on rdata (sel=0) after the edge that samples the last field bit of the second frame.
- R7: A value that appears in one frame only, with the old code returning in the next frame, leaves the received code and irq unchanged.
- R8: irq is set exactly when the received code takes a new value. A confirmed value equal to the current code sets no interrupt.
- R9: irq stays set until a read strobe with sel=0. If a new code is accepted at the same edge as that clearing read, irq stays set.
- R10: A write with sel=0 has no effect on the received code.
- R11: Without a new rising fsc edge, the frame counter stops at the end of the frame. No further bits are sampled, and dout stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial data clock, two cycles per bit |
| rst_n | input | 1 | Active-low reset |
| fsc | input | 1 | Frame sync; a rising edge starts a frame |
| din | input | 1 | Serial receive data |
| dout | output | 1 | Serial transmit data, idle high |
| sel | input | 1 | Register select: 0 received code, 1 transmit code |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe; clears irq when sel=0 |
| wdata | input | SLOT_W | Host write data |
| rdata | output | SLOT_W | Selected register value |
| irq | output | 1 | Sticky change interrupt |

## Verification
A wrong frame counter shows up within one frame: dout bits appear at the wrong positions, or fail to stay high outside the field. A corrupted candidate or stored code causes a missing or premature accept. That error is visible on rdata and irq at the end of the second frame of a sequence, or as a spurious change after a one-frame glitch. A sampling-phase error shows up when din carries deliberately wrong values in the first half of each bit. A counter that does not stop when sync is absent is exposed when frames without sync leave a later single frame able to change the code.

// File: rtl/cit_pkg.sv
package cit_pkg;
   typedef enum logic {
      SEL_RXCODE = 1'b0,
      SEL_TXCODE = 1'b1
   } cit_sel_e;
endpackage

// File: rtl/cit_slot_timer.sv
module cit_slot_timer #(
   parameter int FRAME_BITS = 96,
   parameter int SLOT_POS   = 26,
   parameter int SLOT_W     = 4,
   parameter int IDX_W      = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsc,
   output logic             in_slot,
   output logic [IDX_W-1:0] slot_idx,
   output logic             smp_stb,
   output logic             smp_last
);
   localparam int CYC_W = $clog2(2 * FRAME_BITS);
   localparam int BIT_W = CYC_W - 1;
   localparam logic [CYC_W-1:0] CYC_END = CYC_W'(2 * FRAME_BITS - 1);

   logic             fsc_q;
   logic [CYC_W-1:0] cyc;
   logic [BIT_W-1:0] bit_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsc_q <= 1'b0;
         cyc   <= CYC_END;
      end else begin
         fsc_q <= fsc;
         if (fsc && !fsc_q)
            cyc <= '0;
         else if (cyc != CYC_END)
            cyc <= cyc + 1'b1;
      end
   end

   assign bit_pos  = cyc[CYC_W-1:1];
   assign in_slot  = (int'(bit_pos) >= SLOT_POS) && (int'(bit_pos) < SLOT_POS + SLOT_W);
   assign slot_idx = IDX_W'(int'(bit_pos) - SLOT_POS);
   assign smp_stb  = in_slot && cyc[0];
   assign smp_last = smp_stb && (int'(slot_idx) == SLOT_W - 1);
endmodule

// File: rtl/cit_rx_filter.sv
module cit_rx_filter #(
   parameter int SLOT_W    = 4,
   parameter int IDX_W     = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              din,
   input  logic              smp_stb,
   input  logic              smp_last,
   input  logic [IDX_W-1:0]  slot_idx,
   input  logic              clr_req,
   output logic [SLOT_W-1:0] code_o,
   output logic              irq_o
);
   logic [IDX_W-1:0]  ord;
   logic [SLOT_W-1:0] cap, word, cand;
   logic              accept;

   if (MSB_FIRST) begin : g_msb
      assign ord = IDX_W'(SLOT_W - 1) - slot_idx;
   end else begin : g_lsb
      assign ord = slot_idx;
   end

   always_comb begin
      word      = cap;
      word[ord] = din;
   end

   assign accept = smp_last && (word == cand) && (word != code_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap    <= '1;
         cand   <= '1;
         code_o <= '1;
         irq_o  <= 1'b0;
      end else begin
         if (smp_stb)
            cap <= word;
         if (smp_last)
            cand <= word;
         if (accept)
            code_o <= word;
         if (accept)
            irq_o <= 1'b1;
         else if (clr_req)
            irq_o <= 1'b0;
      end
   end
endmodule

// File: rtl/cit_tx_driver.sv
module cit_tx_driver #(
   parameter int SLOT_W    = 4,
   parameter int IDX_W     = 2,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [SLOT_W-1:0] wdata,
   input  logic              in_slot,
   input  logic [IDX_W-1:0]  slot_idx,
   output logic [SLOT_W-1:0] code_o,
   output logic              dout
);
   logic [IDX_W-1:0] ord;

   if (MSB_FIRST) begin : g_msb
      assign ord = IDX_W'(SLOT_W - 1) - slot_idx;
   end else begin : g_lsb
      assign ord = slot_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_o <= '1;
      else if (wr_stb)
         code_o <= wdata;
   end

   assign dout = in_slot ? code_o[ord] : 1'b1;
endmodule

// File: rtl/ci_transceiver.sv
module ci_transceiver #(
   parameter int FRAME_BITS = 96,
   parameter int SLOT_POS   = 26,
   parameter int SLOT_W     = 4,
   parameter bit MSB_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsc,
   input  logic              din,
   output logic              dout,
   input  logic              sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [SLOT_W-1:0] wdata,
   output logic [SLOT_W-1:0] rdata,
   output logic              irq
);
   import cit_pkg::*;

   localparam int IDX_W = (SLOT_W > 1) ? $clog2(SLOT_W) : 1;

   if (SLOT_W < 1) begin : g_bad_width
      $error("SLOT_W must be at least 1");
   end
   if (FRAME_BITS < 2) begin : g_bad_frame
      $error("FRAME_BITS must be at least 2");
   end
   if (SLOT_POS < 0 || SLOT_POS + SLOT_W > FRAME_BITS) begin : g_bad_pos
      $error("C/I field must lie inside the frame");
   end

   logic              in_slot, smp_stb, smp_last;
   logic [IDX_W-1:0]  slot_idx;
   logic [SLOT_W-1:0] rx_code, tx_code;
   logic              rx_sel, tx_wr, rx_clr;

   assign rx_sel = (cit_sel_e'(sel) == SEL_RXCODE);
   assign tx_wr  = wr_en && !rx_sel;
   assign rx_clr = rd_en && rx_sel;

   cit_slot_timer #(
      .FRAME_BITS(FRAME_BITS), .SLOT_POS(SLOT_POS), .SLOT_W(SLOT_W), .IDX_W(IDX_W)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .fsc(fsc), .in_slot(in_slot),
      .slot_idx(slot_idx), .smp_stb(smp_stb), .smp_last(smp_last)
   );

   cit_rx_filter #(
      .SLOT_W(SLOT_W), .IDX_W(IDX_W), .MSB_FIRST(MSB_FIRST)
   ) u_rx (
      .clk(clk), .rst_n(rst_n), .din(din), .smp_stb(smp_stb), .smp_last(smp_last),
      .slot_idx(slot_idx), .clr_req(rx_clr), .code_o(rx_code), .irq_o(irq)
   );

   cit_tx_driver #(
      .SLOT_W(SLOT_W), .IDX_W(IDX_W), .MSB_FIRST(MSB_FIRST)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_stb(tx_wr), .wdata(wdata), .in_slot(in_slot),
      .slot_idx(slot_idx), .code_o(tx_code), .dout(dout)
   );

   assign rdata = rx_sel ? rx_code : tx_code;
endmodule

// File: rtl/ci_transceiver_chk.sv
module ci_transceiver_chk #(
   parameter int SLOT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sel,
   input logic              wr_en,
   input logic              rd_en,
   input logic              dout,
   input logic              irq,
   input logic              in_slot,
   input logic [SLOT_W-1:0] rx_code,
   input logic [SLOT_W-1:0] tx_code
);
   AST_CHANGE_SETS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rx_code) |-> irq); // R8
   AST_IRQ_RISE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !$stable(rx_code)); // R8
   AST_READ_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !sel) |=> (!irq || !$stable(rx_code))); // R9
   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(rd_en && !sel)) |=> irq); // R9
   AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel) |=> $stable(tx_code)); // R4
   AST_IDLE_OUTSIDE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      !in_slot |-> dout); // R3
endmodule

bind ci_transceiver ci_transceiver_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .dout(dout),
   .irq(irq), .in_slot(in_slot), .rx_code(rx_code), .tx_code(tx_code)
);

// File: tb/ci_transceiver_bench.sv
module ci_transceiver_bench;
   localparam int FB  = 96;
   localparam int POS = 26;
   localparam int W   = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         fsc = 1'b0, din = 1'b1, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [W-1:0] wdata = '0;
   logic [W-1:0] rdata;
   logic         dout, irq;
   logic [W-1:0] tx_model = '1;
   int           nchk = 0, nerr = 0;

   always #10 clk = ~clk;

   ci_transceiver u_ci_transceiver (
      .clk(clk), .rst_n(rst_n), .fsc(fsc), .din(din), .dout(dout), .sel(sel),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic peek(input logic s, output logic [W-1:0] v);
      @(negedge clk);
      sel = s;
      #1 v = rdata;
   endtask

   task automatic wr_reg(input logic s, input logic [W-1:0] v);
      @(negedge clk);
      sel = s; wr_en = 1'b1; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
      if (s) tx_model = v;
   endtask

   task automatic rd_rx(input logic [W-1:0] exp, input string req);
      @(negedge clk);
      sel = 1'b0; rd_en = 1'b1;
      #1 chk(req, rdata, exp);
      @(negedge clk);
      rd_en = 1'b0;
      chk("R9 irq cleared by read", irq, 0);
   endtask

   task automatic frame(input logic [W-1:0] rxc, input bit use_fsc, input bit half_bad, input bit rd_mid);
      @(negedge clk);
      fsc = use_fsc; din = 1'b1;
      @(posedge clk);
      for (int k = 0; k < 2 * FB; k++) begin
         int   b;
         bit   inf;
         logic bv, exp_o;
         @(negedge clk);
         fsc = 1'b0;
         b   = k / 2;
         inf = (b >= POS) && (b < POS + W);
         bv  = inf ? rxc[W-1-(b-POS)] : 1'b1;
         din = (half_bad && (k % 2 == 0)) ? ~bv : bv;
         if (rd_mid && k == 2 * (POS + W) - 1) begin
            sel = 1'b0; rd_en = 1'b1;
         end else if (rd_mid && k == 2 * (POS + W)) begin
            rd_en = 1'b0;
         end
         exp_o = (use_fsc && inf) ? tx_model[W-1-(b-POS)] : 1'b1;
         #1;
         if (k % 2 == 0 && (inf || b == POS - 1 || b == POS + W)) begin
            if (!use_fsc) chk("R11 dout idle without sync", dout, exp_o);
            else if (inf) chk("R3 dout field bit", dout, exp_o);
            else chk("R2 dout idle at field boundary", dout, exp_o);
         end
      end
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      peek(1'b0, v); chk("R1 rx code reset", v, 4'hF);
      peek(1'b1, v); chk("R1 tx code reset", v, 4'hF);
      chk("R1 irq reset", irq, 0);
      chk("R1 dout reset", dout, 1);
   endtask

   task automatic t_tx();
      logic [W-1:0] v;
      wr_reg(1'b1, 4'hA);
      peek(1'b1, v); chk("R4 tx readback", v, 4'hA);
      frame(4'hF, 1, 0, 0);
      peek(1'b0, v); chk("R8 rx unchanged", v, 4'hF);
      chk("R8 no irq for same code", irq, 0);
   endtask

   task automatic t_accept();
      logic [W-1:0] v;
      frame(4'h5, 1, 0, 0);
      peek(1'b0, v); chk("R6 one frame not accepted", v, 4'hF);
      chk("R6 no irq after one frame", irq, 0);
      frame(4'h5, 1, 0, 0);
      chk("R8 irq on accepted change", irq, 1);
      rd_rx(4'h5, "R6 accepted after two frames");
   endtask

   task automatic t_glitch();
      logic [W-1:0] v;
      frame(4'h3, 1, 0, 0);
      frame(4'h5, 1, 0, 0);
      peek(1'b0, v); chk("R7 glitch ignored", v, 4'h5);
      chk("R7 no irq on glitch", irq, 0);
      frame(4'h5, 1, 0, 0);
      chk("R8 confirmed same code no irq", irq, 0);
   endtask

   task automatic t_halfbit();
      frame(4'h9, 1, 1, 0);
      frame(4'h9, 1, 1, 0);
      chk("R5 irq with half-bit noise", irq, 1);
      rd_rx(4'h9, "R5 sampled in second half");
   endtask

   task automatic t_setwins();
      logic [W-1:0] v;
      wr_reg(1'b1, 4'h3);
      frame(4'hC, 1, 0, 0);
      frame(4'hC, 1, 0, 1);
      chk("R9 set wins over clear", irq, 1);
      peek(1'b0, v); chk("R9 rx after set-wins", v, 4'hC);
      rd_rx(4'hC, "R9 read after set-wins");
   endtask

   task automatic t_ignore();
      logic [W-1:0] v;
      wr_reg(1'b0, 4'h0);
      peek(1'b0, v); chk("R10 rx write ignored", v, 4'hC);
      peek(1'b1, v); chk("R4 tx kept", v, 4'h3);
   endtask

   task automatic t_nofsc();
      logic [W-1:0] v;
      frame(4'h0, 0, 0, 0);
      frame(4'h0, 0, 0, 0);
      peek(1'b0, v); chk("R11 no sampling without sync", v, 4'hC);
      chk("R11 no irq without sync", irq, 0);
      frame(4'h0, 1, 0, 0);
      peek(1'b0, v); chk("R11 single synced frame not accepted", v, 4'hC);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_tx();
      t_accept();
      t_glitch();
      t_halfbit();
      t_setwins();
      t_ignore();
      t_nofsc();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule